// File: doc/BRIEF.md
# Receive Frame Descriptor Writer

This block moves received frames from the MAC into memory through a linked list of receive descriptors. Each descriptor is four 32-bit words: a status-and-length word, the buffer start address, a spare word and the address of the next descriptor. When a frame begins, the block fetches the current descriptor. It checks that the engine owns the descriptor, packs the incoming bytes into 32-bit words and writes them into the descriptor's buffer. At the end of the frame it writes a status word back, which returns ownership to the CPU, and then follows the link to the next descriptor.

Software points the engine at the head of a list with a load strobe. It picks whether over-length frames are kept or dropped, and whether descriptors are tagged for interrupt. Single-cycle event pulses feed the interrupt controller. The memory port is word wide, with one request per cycle and read data one cycle after a read request. The byte stream uses a valid/ready handshake and marks the final byte of each frame.

Top module: `rxdma_writer`

## Requirements
- R1: Word 0 of a descriptor (at `cur_desc`) holds status and length, word 1 (at `cur_desc`+4) holds the buffer start address, and word 3 (at `cur_desc`+12) holds the next-descriptor link. All three are read before any frame byte is accepted.
- R2: A descriptor is engine-owned only when status bits [31:30] equal 2'b10. When a frame arrives on a descriptor that is not engine-owned, its bytes are consumed and nothing is written to memory. `ev_unavail` pulses alone and `cur_desc` keeps its value.
- R3: Frame byte n is stored in the word at buffer + 4*floor(n/4), in bits [8*(n mod 4)+7 : 8*(n mod 4)]. Unused upper bytes of a final partial word are written as zero. `ev_early` pulses in the cycle after the first buffer word of an engine-owned frame is written.
- R4: For a kept frame, the written-back status word has bits [31:30] = 2'b00, bit 20 (good) set, and bits [15:0] equal to the frame byte count plus 4. All other bits are zero unless R5 or R6 sets them.
- R5: Status bit 16 is set in the written-back word only when `rx_int_en` is high.
- R6: A frame longer than MAX_LEN (1518) bytes with `accept_long` high is stored in full. Its status carries bit 19 as well as the good bit, and `ev_good`, `ev_rxint` and `ev_too_long` pulse together.
- R7: A frame longer than MAX_LEN with `accept_long` low gets no status write-back. Only `ev_too_long` pulses, and `cur_desc` is unchanged. A frame of exactly MAX_LEN bytes is a normal good frame.
- R8: After a kept frame, `cur_desc` holds the link read from word 3. `ev_good` and `ev_rxint` pulse for one cycle, in the cycle after the status write-back.
- R9: After reset, `cur_desc` is 0 and every event output is low. A `list_load` pulse while the block is idle copies `list_base` into `cur_desc` on the next clock edge.
- R10: `poll_demand` has no effect on any output. Reception proceeds without it.
- R11: `rx_ready` is low in reset, while idle and during the descriptor fetch. No memory read is issued in a cycle where `rx_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Stream byte valid |
| rx_data | input | 8 | Stream byte |
| rx_last | input | 1 | Marks the final byte of a frame |
| rx_ready | output | 1 | Byte accepted when high together with rx_valid |
| mem_req | output | 1 | Memory request this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| list_base | input | 32 | Head of the descriptor list |
| list_load | input | 1 | Load list_base into the current-descriptor pointer when idle |
| cur_desc | output | 32 | Current descriptor address |
| accept_long | input | 1 | Keep frames longer than MAX_LEN |
| rx_int_en | input | 1 | Tag kept descriptors with the interrupt bit |
| poll_demand | input | 1 | Receive poll demand, accepted and ignored |
| ev_early | output | 1 | First buffer word of a frame written |
| ev_good | output | 1 | Frame kept and handed to the CPU |
| ev_rxint | output | 1 | Receive interrupt event |
| ev_too_long | output | 1 | Frame exceeded MAX_LEN |
| ev_unavail | output | 1 | Current descriptor not engine-owned |

## Verification
The fetch takes four cycles from the first valid byte: the status read, the buffer read, the link read and the link capture. Every fourth byte and the final byte cost one extra cycle for the word write, during which `rx_ready` is low. The status write-back comes one cycle after the last word write, and `cur_desc` and the end-of-frame events change at the clock edge that ends that write-back cycle. The bench drives each byte at a falling edge and waits on `rx_ready` instead of assuming a fixed cadence. Monitors at falling edges count every event pulse, and memory and `cur_desc` are compared only after an end-of-frame event plus two settling cycles, so a check never depends on where a pulse falls relative to the last byte.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;

  localparam int STAT_LEN_W = 16;
  localparam logic [1:0] OWN_ENGINE = 2'b10;
  localparam int CRC_BYTES = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_STAT,
    ST_RD_BUF,
    ST_RD_LINK,
    ST_CAP_LINK,
    ST_DATA,
    ST_WB
  } rx_state_e;

  // Status word returned to the CPU for a kept frame.
  function automatic logic [31:0] rx_status_word(input logic [STAT_LEN_W-1:0] len,
                                                 input logic long_f,
                                                 input logic int_f);
    logic [31:0] w;
    w         = '0;
    w[20]     = 1'b1;
    w[19]     = long_f;
    w[16]     = int_f;
    w[15:0]   = len + 16'(CRC_BYTES);
    return w;
  endfunction

  function automatic logic engine_owned(input logic [31:0] stat);
    return stat[31:30] == OWN_ENGINE;
  endfunction

  // Merge one byte into a little-endian word at the given lane.
  function automatic logic [31:0] put_byte(input logic [31:0] w,
                                           input logic [7:0] b,
                                           input logic [1:0] lane);
    return w | ({24'b0, b} << {lane, 3'b000});
  endfunction

endpackage

// File: rtl/rxdma_pack.sv
module rxdma_pack
  import rxdma_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             take,
  input  logic [7:0]       byte_in,
  input  logic             last_in,
  input  logic             drain,
  output logic             pend,
  output logic [31:0]      pend_word,
  output logic [LEN_W-3:0] pend_idx,
  output logic             pend_last,
  output logic [LEN_W-1:0] byte_cnt
);

  logic [31:0] acc;
  logic [1:0]  lane;

  assign lane = byte_cnt[1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc       <= '0;
      byte_cnt  <= '0;
      pend      <= 1'b0;
      pend_word <= '0;
      pend_idx  <= '0;
      pend_last <= 1'b0;
    end else if (clear) begin
      acc       <= '0;
      byte_cnt  <= '0;
      pend      <= 1'b0;
      pend_last <= 1'b0;
    end else begin
      if (drain) begin
        pend <= 1'b0;
      end
      if (take) begin
        byte_cnt <= byte_cnt + 1'b1;
        if (lane == 2'd3 || last_in) begin
          pend      <= 1'b1;
          pend_word <= put_byte(acc, byte_in, lane);
          pend_idx  <= byte_cnt[LEN_W-1:2];
          pend_last <= last_in;
          acc       <= '0;
        end else begin
          acc <= put_byte(acc, byte_in, lane);
        end
      end
    end
  end

endmodule

// File: rtl/rxdma_ctrl.sv
module rxdma_ctrl
  import rxdma_pkg::*;
#(
  parameter int LEN_W   = 16,
  parameter int MAX_LEN = 1518
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  output logic             rx_ready,
  output logic             clear,
  output logic             drain,
  input  logic             pend,
  input  logic [31:0]      pend_word,
  input  logic [LEN_W-3:0] pend_idx,
  input  logic             pend_last,
  input  logic [LEN_W-1:0] byte_cnt,
  output logic             mem_req,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic [31:0]      mem_rdata,
  input  logic [31:0]      list_base,
  input  logic             list_load,
  output logic [31:0]      cur_desc,
  input  logic             accept_long,
  input  logic             rx_int_en,
  output logic             ev_early,
  output logic             ev_good,
  output logic             ev_rxint,
  output logic             ev_too_long,
  output logic             ev_unavail
);

  localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_LEN);

  rx_state_e        st, nxt;
  logic             own_q;
  logic [31:0]      buf_q;
  logic [31:0]      link_q;
  logic [LEN_W-1:0] word_off;
  logic             store_word;
  logic             is_long;
  logic             keep;

  assign word_off   = {pend_idx, 2'b00};
  assign store_word = own_q && (accept_long || (word_off < MAX_L));
  assign is_long    = byte_cnt > MAX_L;
  assign keep       = own_q && (!is_long || accept_long);
  assign rx_ready   = (st == ST_DATA) && !pend;
  assign clear      = (st == ST_IDLE) && rx_valid;

  always_comb begin
    nxt       = st;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cur_desc;
    mem_wdata = '0;
    drain     = 1'b0;
    case (st)
      ST_IDLE:     if (rx_valid) nxt = ST_RD_STAT;
      ST_RD_STAT: begin
        mem_req = 1'b1;
        nxt     = ST_RD_BUF;
      end
      ST_RD_BUF: begin
        mem_req  = 1'b1;
        mem_addr = cur_desc + 32'd4;
        nxt      = ST_RD_LINK;
      end
      ST_RD_LINK: begin
        mem_req  = 1'b1;
        mem_addr = cur_desc + 32'd12;
        nxt      = ST_CAP_LINK;
      end
      ST_CAP_LINK: nxt = ST_DATA;
      ST_DATA: begin
        if (pend) begin
          drain     = 1'b1;
          mem_req   = store_word;
          mem_we    = store_word;
          mem_addr  = buf_q + 32'(word_off);
          mem_wdata = pend_word;
          if (pend_last) nxt = ST_WB;
        end
      end
      ST_WB: begin
        if (keep) begin
          mem_req   = 1'b1;
          mem_we    = 1'b1;
          mem_addr  = cur_desc;
          mem_wdata = rx_status_word(STAT_LEN_W'(byte_cnt), is_long, rx_int_en);
        end
        nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      own_q       <= 1'b0;
      buf_q       <= '0;
      link_q      <= '0;
      cur_desc    <= '0;
      ev_early    <= 1'b0;
      ev_good     <= 1'b0;
      ev_rxint    <= 1'b0;
      ev_too_long <= 1'b0;
      ev_unavail  <= 1'b0;
    end else begin
      st          <= nxt;
      ev_early    <= 1'b0;
      ev_good     <= 1'b0;
      ev_rxint    <= 1'b0;
      ev_too_long <= 1'b0;
      ev_unavail  <= 1'b0;
      case (st)
        ST_IDLE:     if (list_load) cur_desc <= list_base;
        ST_RD_BUF:   own_q  <= engine_owned(mem_rdata);
        ST_RD_LINK:  buf_q  <= mem_rdata;
        ST_CAP_LINK: link_q <= mem_rdata;
        ST_DATA:     if (pend && store_word && pend_idx == '0) ev_early <= 1'b1;
        ST_WB: begin
          if (keep) begin
            cur_desc    <= link_q;
            ev_good     <= 1'b1;
            ev_rxint    <= 1'b1;
            ev_too_long <= is_long;
          end else if (!own_q) begin
            ev_unavail  <= 1'b1;
          end else begin
            ev_too_long <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/rxdma_writer.sv
module rxdma_writer
  import rxdma_pkg::*;
#(
  parameter int LEN_W   = 16,
  parameter int MAX_LEN = 1518
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_last,
  output logic        rx_ready,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic [31:0] list_base,
  input  logic        list_load,
  output logic [31:0] cur_desc,
  input  logic        accept_long,
  input  logic        rx_int_en,
  input  logic        poll_demand,
  output logic        ev_early,
  output logic        ev_good,
  output logic        ev_rxint,
  output logic        ev_too_long,
  output logic        ev_unavail
);

  logic             clear, take, drain;
  logic             pend, pend_last;
  logic [31:0]      pend_word;
  logic [LEN_W-3:0] pend_idx;
  logic [LEN_W-1:0] byte_cnt;
  logic             poll_unused;

  // Poll demand is accepted but reception never waits on it.
  assign poll_unused = poll_demand;
  assign take        = rx_valid && rx_ready;

  rxdma_pack #(.LEN_W(LEN_W)) u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear),
    .take      (take),
    .byte_in   (rx_data),
    .last_in   (rx_last),
    .drain     (drain),
    .pend      (pend),
    .pend_word (pend_word),
    .pend_idx  (pend_idx),
    .pend_last (pend_last),
    .byte_cnt  (byte_cnt)
  );

  rxdma_ctrl #(.LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_valid    (rx_valid),
    .rx_ready    (rx_ready),
    .clear       (clear),
    .drain       (drain),
    .pend        (pend),
    .pend_word   (pend_word),
    .pend_idx    (pend_idx),
    .pend_last   (pend_last),
    .byte_cnt    (byte_cnt),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_rdata   (mem_rdata),
    .list_base   (list_base),
    .list_load   (list_load),
    .cur_desc    (cur_desc),
    .accept_long (accept_long),
    .rx_int_en   (rx_int_en),
    .ev_early    (ev_early),
    .ev_good     (ev_good),
    .ev_rxint    (ev_rxint),
    .ev_too_long (ev_too_long),
    .ev_unavail  (ev_unavail)
  );

endmodule

// File: rtl/rxdma_writer_chk.sv
module rxdma_writer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_ready,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic [31:0] cur_desc,
  input logic        ev_early,
  input logic        ev_good,
  input logic        ev_rxint,
  input logic        ev_too_long,
  input logic        ev_unavail
);

  // R4: a write to the current descriptor returns it to the CPU as good
  assert_owner_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_addr == cur_desc) |-> (mem_wdata[31:30] == 2'b00 && mem_wdata[20]));

  // R8: a good event follows a status write to the previous descriptor
  assert_good_after_wb_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_good |-> ($past(mem_req && mem_we) && $past(mem_addr) == $past(cur_desc)));

  // R8: interrupt event comes only with a good frame
  assert_rxint_with_good_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rxint |-> ev_good);

  // R2: unavailable descriptor leaves the pointer and raises nothing else
  assert_unavail_alone_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_unavail |-> (cur_desc == $past(cur_desc) && !ev_good && !ev_too_long && !ev_early));

  // R7: a dropped long frame keeps the pointer
  assert_drop_keeps_ptr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_too_long && !ev_good) |-> cur_desc == $past(cur_desc));

  // R11: no reads while bytes are being accepted
  assert_no_read_in_data_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> !(mem_req && !mem_we));

  // R3: early notice follows a memory write
  assert_early_after_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_early |-> $past(mem_req && mem_we));

  // R2: end-of-frame outcomes are exclusive
  assert_outcome_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_good, ev_unavail}));

endmodule

bind rxdma_writer rxdma_writer_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rx_ready    (rx_ready),
  .mem_req     (mem_req),
  .mem_we      (mem_we),
  .mem_addr    (mem_addr),
  .mem_wdata   (mem_wdata),
  .cur_desc    (cur_desc),
  .ev_early    (ev_early),
  .ev_good     (ev_good),
  .ev_rxint    (ev_rxint),
  .ev_too_long (ev_too_long),
  .ev_unavail  (ev_unavail)
);

// File: tb/rxdma_writer_test.sv
`timescale 1ns/1ps
module rxdma_writer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_last = 1'b0;
  logic        rx_ready;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic [31:0] list_base = '0;
  logic        list_load = 1'b0;
  logic [31:0] cur_desc;
  logic        accept_long = 1'b0;
  logic        rx_int_en = 1'b0;
  logic        poll_demand = 1'b0;
  logic        ev_early, ev_good, ev_rxint, ev_too_long, ev_unavail;

  always #4 clk = ~clk;

  rxdma_writer uut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
    .rx_ready(rx_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .list_base(list_base),
    .list_load(list_load), .cur_desc(cur_desc), .accept_long(accept_long),
    .rx_int_en(rx_int_en), .poll_demand(poll_demand), .ev_early(ev_early),
    .ev_good(ev_good), .ev_rxint(ev_rxint), .ev_too_long(ev_too_long),
    .ev_unavail(ev_unavail)
  );

  logic [31:0] mem [0:4095];
  logic [7:0]  fbytes [0:1699];

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr[13:2]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[13:2]];
    end
  end

  int n_early = 0, n_good = 0, n_rxint = 0, n_long = 0, n_unav = 0;
  always @(negedge clk) begin
    if (ev_early)    n_early++;
    if (ev_good)     n_good++;
    if (ev_rxint)    n_rxint++;
    if (ev_too_long) n_long++;
    if (ev_unavail)  n_unav++;
  end

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_status(input int len, input bit lng, input bit ie);
    logic [31:0] w;
    w = 32'h0010_0000 + 32'(len) + 32'd4;
    if (lng) w = w + 32'h0008_0000;
    if (ie)  w = w + 32'h0001_0000;
    return w;
  endfunction

  task automatic set_desc(input logic [31:0] a, input bit own, input logic [31:0] b,
                          input logic [31:0] lnk);
    mem[a[13:2]]        = own ? 32'h8000_0000 : 32'h0;
    mem[a[13:2] + 12'd1] = b;
    mem[a[13:2] + 12'd2] = 32'h0;
    mem[a[13:2] + 12'd3] = lnk;
  endtask

  task automatic prep_buf(input logic [31:0] b, input int len);
    for (int i = 0; i < len + 8; i += 4) mem[(b + 32'(i)) >> 2] = 32'hA5A5_A5A5;
    for (int i = 0; i < len; i++) fbytes[i] = 8'($urandom);
  endtask

  // Expected memory word for stored byte positions, zero padding in the tail word.
  task automatic check_buf(input string req, input logic [31:0] b, input int len);
    int bad = 0;
    logic [31:0] w, e;
    for (int wi = 0; wi * 4 < len; wi++) begin
      w = mem[(b >> 2) + 32'(wi)];
      e = '0;
      for (int k = 0; k < 4; k++)
        if (wi * 4 + k < len) e[8*k +: 8] = fbytes[wi*4 + k];
      if (w !== e) bad++;
    end
    check(req, 32'(bad), 32'd0);
  endtask

  task automatic send_frame(input int len);
    int g0, u0, l0;
    g0 = n_good; u0 = n_unav; l0 = n_long;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = fbytes[i]; rx_last = (i == len - 1);
      while (!rx_ready) @(negedge clk);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0;
    for (int t = 0; t < 40; t++) begin
      if (n_good != g0 || n_unav != u0 || n_long != l0) break;
      @(negedge clk);
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic load_list(input logic [31:0] a);
    @(negedge clk); list_base = a; list_load = 1'b1;
    @(negedge clk); list_load = 1'b0;
  endtask

  initial begin
    int e0, g0, r0, l0, u0, len;
    bit ie;
    void'($urandom(32'd4242));
    for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    check("R9 reset cur_desc", cur_desc, 32'h0);
    check("R9 reset events", {27'b0, ev_early, ev_good, ev_rxint, ev_too_long, ev_unavail}, 32'h0);
    check("R11 reset ready", {31'b0, rx_ready}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    set_desc(32'h1000, 1, 32'h2000, 32'h1010);
    set_desc(32'h1010, 1, 32'h3000, 32'h1020);
    set_desc(32'h1020, 0, 32'h3800, 32'h1030);
    load_list(32'h1000);
    check("R9 list load", cur_desc, 32'h1000);

    g0 = n_good; u0 = n_unav;
    for (int i = 0; i < 3; i++) begin @(negedge clk); poll_demand = 1'b1; end
    @(negedge clk); poll_demand = 1'b0; repeat (2) @(negedge clk);
    check("R10 poll no pointer change", cur_desc, 32'h1000);
    check("R10 poll no events", 32'((n_good - g0) + (n_unav - u0) + n_early), 32'h0);

    // Frame A: 60 bytes, interrupt tagging off
    prep_buf(32'h2000, 60);
    e0 = n_early; r0 = n_rxint; l0 = n_long;
    send_frame(60);
    check("R4 status A", mem[32'h1000 >> 2], exp_status(60, 0, 0));
    check("R8 pointer follows link A", cur_desc, 32'h1010);
    check("R8 rxint event A", 32'(n_rxint - r0), 32'd1);
    check("R3 early event A", 32'(n_early - e0), 32'd1);
    check("R6 no long flag A", 32'(n_long - l0), 32'd0);
    check_buf("R1 R3 buffer A", 32'h2000, 60);

    // Frame B: single byte, interrupt tagging on
    rx_int_en = 1'b1;
    prep_buf(32'h3000, 1);
    send_frame(1);
    check("R5 status B", mem[32'h1010 >> 2], exp_status(1, 0, 1));
    check("R3 padded word B", mem[32'h3000 >> 2], {24'h0, fbytes[0]});
    check("R8 pointer B", cur_desc, 32'h1020);

    // Frame C: CPU-owned descriptor
    prep_buf(32'h3800, 30);
    g0 = n_good; u0 = n_unav; e0 = n_early;
    send_frame(30);
    check("R2 unavail event", 32'(n_unav - u0), 32'd1);
    check("R2 no good", 32'(n_good - g0), 32'd0);
    check("R2 no early", 32'(n_early - e0), 32'd0);
    check("R2 pointer kept", cur_desc, 32'h1020);
    check("R2 status untouched", mem[32'h1020 >> 2], 32'h0);
    check("R2 buffer untouched", mem[32'h3800 >> 2], 32'hA5A5_A5A5);

    // Frame D: long frame dropped
    set_desc(32'h1000, 1, 32'h2000, 32'h1010);
    load_list(32'h1000);
    accept_long = 1'b0;
    prep_buf(32'h2000, 1600);
    g0 = n_good; l0 = n_long;
    send_frame(1600);
    check("R7 long flag", 32'(n_long - l0), 32'd1);
    check("R7 no good", 32'(n_good - g0), 32'd0);
    check("R7 pointer kept", cur_desc, 32'h1000);
    check("R7 no writeback", mem[32'h1000 >> 2], 32'h8000_0000);

    // Frame E: long frame kept
    accept_long = 1'b1;
    prep_buf(32'h2000, 1600);
    g0 = n_good; l0 = n_long;
    send_frame(1600);
    check("R6 status long", mem[32'h1000 >> 2], exp_status(1600, 1, 1));
    check("R6 good and long", 32'((n_good - g0) * 16 + (n_long - l0)), 32'h11);
    check_buf("R6 whole long buffer", 32'h2000, 1600);
    check("R6 pointer", cur_desc, 32'h1010);

    // Frame F: exactly the maximum length with long frames refused
    accept_long = 1'b0;
    set_desc(32'h1010, 1, 32'h3000, 32'h1020);
    prep_buf(32'h3000, 1518);
    l0 = n_long;
    send_frame(1518);
    check("R7 boundary status", mem[32'h1010 >> 2], exp_status(1518, 0, 1));
    check("R7 boundary no long", 32'(n_long - l0), 32'd0);

    // Frame G: one byte over the limit
    set_desc(32'h1020, 1, 32'h3800, 32'h1030);
    prep_buf(32'h3800, 1519);
    g0 = n_good;
    send_frame(1519);
    check("R7 one over dropped", 32'(n_good - g0), 32'd0);
    check("R7 one over pointer", cur_desc, 32'h1020);

    // Random lengths and tagging
    for (int k = 0; k < 6; k++) begin
      len = 1 + int'($urandom % 200);
      ie = 1'($urandom);
      rx_int_en = ie;
      set_desc(32'h1000, 1, 32'h2000, 32'h1010);
      load_list(32'h1000);
      prep_buf(32'h2000, len);
      send_frame(len);
      check("R4 R5 random status", mem[32'h1000 >> 2], exp_status(len, 0, ie));
      check_buf("R3 random buffer", 32'h2000, len);
      check("R8 random pointer", cur_desc, 32'h1010);
    end

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule